// File: doc/BRIEF.md
# External Memory Bus Cycle Generator

This block sequences the strobes of a multiplexed external memory bus for an 8051-class processor core. It runs directly on the oscillator clock. A free-running phase counter divides time into machine cycles of twelve oscillator periods. At the end of every machine cycle the block samples the core's requests and commits the next cycle to one of four kinds: idle, code fetch, data read or data write. A data request wins over a fetch request.

In a code-fetch cycle the address-latch strobe pulses twice and the program-store read strobe pulses twice, once per fetched byte. In a data cycle only the first latch pulse and one read or write strobe appear. The latch pulse is omitted from the second half, and both program-store pulses are omitted. The low address byte and the write data share one bus with an output enable, and the high address byte goes out on a separate port. A single control bit, set by a write to the auxiliary control address, keeps the latch strobe high through idle and fetch cycles. This lowers emissions when no external code memory is in use.

Top module: `xbus_cycle_gen`

## Requirements
- R1: While reset is asserted the block is in phase 0 of an idle cycle: `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe`, `cyc_end` and `rd_valid` are 0, `ale` is 1, and the quiet bit is 0.
- R2: In idle and fetch cycles with the quiet bit clear, `ale` is 1 in phases 0–1 and 6–7 and 0 in all other phases, giving two pulses per 12 clocks. In idle cycles `ad_oe` is 0 and `a_hi` equals `p2_reg`.
- R3: In a fetch cycle `psen_n` is 0 in phases 3–5 and 9–11. The bus drives `ad_out` = low byte of the fetch address in phases 0–1 and low byte of (fetch address + 1) in phases 6–7, with `ad_oe` = 1, and releases it elsewhere. `a_hi` is the high byte of the same address for each half.
- R4: In a data cycle `ale` is 1 only in phases 0–1, and `psen_n` stays 1 for all 12 phases.
- R5: In a data read cycle `rd_n` is 0 in phases 5–10. This is six clocks wide and falls three clocks after `ale` falls. `ad_oe` is 1 only in phases 0–1. The value on `ad_in` in phase 10 appears on `rd_data`, with `rd_valid` = 1, during phase 11.
- R6: In a data write cycle `wr_n` is 0 in phases 5–10. `ad_out` carries the address low byte in phases 0–1 and the write data in phases 4–11, with `ad_oe` = 1 in both windows and 0 in phases 2–3.
- R7: In a data cycle with `data_wide` = 1, `a_hi` is the high byte of the data address. With `data_wide` = 0, `a_hi` follows `p2_reg`.
- R8: Requests and their address, width and write data are sampled only at the clock edge that ends phase 11. `cyc_end` is 1 exactly in phase 11. A data request takes precedence over a fetch request, and with no request the next cycle is idle.
- R9: A register write with `sfr_addr` = 0x8E loads the quiet bit from `sfr_wdata[0]`, effective from the next clock. While the bit is 1, `ale` is 1 for all phases of idle and fetch cycles, and data cycles still pulse `ale` in phases 0–1 only. A write to any other address leaves the bit unchanged.
- R10: Writing 0 to bit 0 at 0x8E clears the quiet bit and restores the normal `ale` pattern of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Request a code-fetch cycle next |
| fetch_addr | input | 16 | Address of the first code byte |
| data_req | input | 1 | Request a data cycle next |
| data_we | input | 1 | 1 = data write, 0 = data read |
| data_wide | input | 1 | 1 = 16-bit data address, 0 = 8-bit |
| data_addr | input | 16 | Data address |
| data_wdata | input | 8 | Data to write |
| p2_reg | input | 8 | Upper port register contents |
| sfr_we | input | 1 | Control register write strobe |
| sfr_addr | input | 8 | Control register address |
| sfr_wdata | input | 8 | Control register write data |
| ad_in | input | 8 | Value read from the low bus |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low bus drive value (0 when released) |
| ad_oe | output | 1 | Low bus output enable |
| a_hi | output | 8 | High address port |
| rd_data | output | 8 | Last captured read byte |
| rd_valid | output | 1 | `rd_data` updated this clock |
| cyc_end | output | 1 | Last phase of the machine cycle |

## Verification
The hardest case to reach is a change to the quiet bit landing in the middle of a machine cycle. When that happens, `ale` changes pattern partway through a fetch or idle cycle, but a data cycle must keep its single latch pulse. The stimulus writes the control register at random clocks, and sometimes to a neighbouring address. A directed opening sets the bit during a data cycle and follows it with fetch, read and idle cycles. The bench models the bit one clock after the write, so every phase of every cycle kind is compared against it.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int PH_N   = 12;
  localparam int PHW    = $clog2(PH_N);
  localparam int HALF_I = PH_N / 2;

  typedef logic [PHW-1:0] phase_t;

  localparam phase_t PH_LAST = phase_t'(PH_N - 1);
  localparam phase_t PH_HALF = phase_t'(HALF_I);
  localparam phase_t ALE_W   = phase_t'(2);
  localparam phase_t PSEN_LO = ALE_W + phase_t'(1);
  localparam phase_t PSEN_HI = PH_HALF - phase_t'(1);
  localparam phase_t STB_LO  = ALE_W + phase_t'(3);
  localparam phase_t STB_HI  = STB_LO + phase_t'(5);
  localparam phase_t WDAT_LO = STB_LO - phase_t'(1);

  typedef enum logic [1:0] {CK_IDLE, CK_FETCH, CK_DRD, CK_DWR} ckind_t;

  function automatic logic in_win(phase_t p, phase_t lo, phase_t hi);
    return (p >= lo) && (p <= hi);
  endfunction

  function automatic phase_t half_off(phase_t p);
    return (p >= PH_HALF) ? p - PH_HALF : p;
  endfunction

  function automatic logic is_data(ckind_t k);
    return (k == CK_DRD) || (k == CK_DWR);
  endfunction
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr
  import xbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase,
  output logic   last
);
  assign last = (phase == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (last) phase <= '0;
    else           phase <= phase + phase_t'(1);
  end
endmodule

// File: rtl/xbus_cycle_reg.sv
module xbus_cycle_reg
  import xbus_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [7:0]  AUX_ADDR = 8'h8E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          last,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  input  logic          data_req,
  input  logic          data_we,
  input  logic          data_wide,
  input  logic [AW-1:0] data_addr,
  input  logic [DW-1:0] data_wdata,
  input  logic          sfr_we,
  input  logic [7:0]    sfr_addr,
  input  logic [7:0]    sfr_wdata,
  output ckind_t        kind,
  output logic [AW-1:0] addr,
  output logic          wide,
  output logic [DW-1:0] wdata,
  output logic          quiet
);
  ckind_t next_kind;

  always_comb begin
    if (data_req)       next_kind = data_we ? CK_DWR : CK_DRD;
    else if (fetch_req) next_kind = CK_FETCH;
    else                next_kind = CK_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind  <= CK_IDLE;
      addr  <= '0;
      wide  <= 1'b0;
      wdata <= '0;
    end else if (last) begin
      kind  <= next_kind;
      addr  <= data_req ? data_addr : fetch_addr;
      wide  <= data_req & data_wide;
      wdata <= data_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               quiet <= 1'b0;
    else if (sfr_we && sfr_addr == AUX_ADDR)  quiet <= sfr_wdata[0];
  end
endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  phase_t        phase,
  input  ckind_t        kind,
  input  logic [AW-1:0] addr,
  input  logic          wide,
  input  logic [DW-1:0] wdata,
  input  logic          quiet,
  input  logic [AW-DW-1:0] p2_reg,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] a_hi
);
  phase_t        hp;
  logic          second, data_k, addr_win, strobe_win;
  logic          addr_drive, wdat_drive, ale_norm;
  logic [AW-1:0] cur_addr;

  always_comb begin
    hp         = half_off(phase);
    second     = (phase >= PH_HALF);
    data_k     = is_data(kind);
    addr_win   = (hp < ALE_W);
    strobe_win = in_win(phase, STB_LO, STB_HI);
    cur_addr   = (kind == CK_FETCH && second) ? addr + 1'b1 : addr;

    ale_norm   = addr_win && !(data_k && second);
    ale        = (quiet && !data_k) ? 1'b1 : ale_norm;
    psen_n     = !(kind == CK_FETCH && in_win(hp, PSEN_LO, PSEN_HI));
    rd_n       = !(kind == CK_DRD && strobe_win);
    wr_n       = !(kind == CK_DWR && strobe_win);

    addr_drive = (kind != CK_IDLE) && addr_win && !(data_k && second);
    wdat_drive = (kind == CK_DWR) && (phase >= WDAT_LO);
    ad_oe      = addr_drive || wdat_drive;
    if (addr_drive)      ad_out = cur_addr[DW-1:0];
    else if (wdat_drive) ad_out = wdata;
    else                 ad_out = '0;

    if (kind == CK_FETCH)     a_hi = cur_addr[AW-1:DW];
    else if (data_k && wide)  a_hi = addr[AW-1:DW];
    else                      a_hi = p2_reg;
  end
endmodule

// File: rtl/xbus_cycle_gen.sv
module xbus_cycle_gen
  import xbus_pkg::*;
#(
  parameter int         AW       = 16,
  parameter int         DW       = 8,
  parameter logic [7:0] AUX_ADDR = 8'h8E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_req,
  input  logic [AW-1:0]    fetch_addr,
  input  logic             data_req,
  input  logic             data_we,
  input  logic             data_wide,
  input  logic [AW-1:0]    data_addr,
  input  logic [DW-1:0]    data_wdata,
  input  logic [AW-DW-1:0] p2_reg,
  input  logic             sfr_we,
  input  logic [7:0]       sfr_addr,
  input  logic [7:0]       sfr_wdata,
  input  logic [DW-1:0]    ad_in,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             cyc_end
);
  phase_t        phase;
  logic          last;
  ckind_t        kind;
  logic [AW-1:0] addr;
  logic          wide;
  logic [DW-1:0] wdata;
  logic          quiet;
  logic          capture;

  xbus_phase_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .phase(phase), .last(last)
  );

  xbus_cycle_reg #(.AW(AW), .DW(DW), .AUX_ADDR(AUX_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .last(last),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .data_req(data_req), .data_we(data_we), .data_wide(data_wide),
    .data_addr(data_addr), .data_wdata(data_wdata),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .kind(kind), .addr(addr), .wide(wide), .wdata(wdata), .quiet(quiet)
  );

  xbus_strobe_dec #(.AW(AW), .DW(DW)) u_dec (
    .phase(phase), .kind(kind), .addr(addr), .wide(wide), .wdata(wdata),
    .quiet(quiet), .p2_reg(p2_reg),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi)
  );

  assign capture = (kind == CK_DRD) && (phase == STB_HI);
  assign cyc_end = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= ad_in;
    end
  end
endmodule

// File: rtl/xbus_cycle_gen_chk.sv
module xbus_cycle_gen_chk
  import xbus_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   ale,
  input logic   psen_n,
  input logic   rd_n,
  input logic   wr_n,
  input logic   ad_oe,
  input logic   cyc_end,
  input ckind_t kind,
  input logic   quiet
);
  AST_ONE_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1); // R4
  AST_PSEN_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> kind == CK_FETCH); // R3
  AST_RD_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!ad_oe && !ale)); // R5
  AST_RD_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> ($past(ale, 4) && !$past(ale, 3))); // R5
  AST_WR_DATA_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe); // R6
  AST_KIND_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cyc_end) |-> $stable(kind)); // R8
  AST_QUIET_HOLDS_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !is_data(kind)) |-> ale); // R9
endmodule

bind xbus_cycle_gen xbus_cycle_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
  .wr_n(wr_n), .ad_oe(ad_oe), .cyc_end(cyc_end), .kind(kind), .quiet(quiet)
);

// File: tb/xbus_cycle_gen_bench.sv
`timescale 1ns/1ps
module xbus_cycle_gen_bench;
  localparam int NCYC = 1500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 0, data_req = 0, data_we = 0, data_wide = 0;
  logic [15:0] fetch_addr = 0, data_addr = 0;
  logic [7:0]  data_wdata = 0, p2_reg = 0, ad_in = 0;
  logic        sfr_we = 0;
  logic [7:0]  sfr_addr = 0, sfr_wdata = 0;
  logic        ale, psen_n, rd_n, wr_n, ad_oe, rd_valid, cyc_end;
  logic [7:0]  ad_out, a_hi, rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xbus_cycle_gen u_xbus_cycle_gen (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .data_req(data_req), .data_we(data_we), .data_wide(data_wide),
    .data_addr(data_addr), .data_wdata(data_wdata), .p2_reg(p2_reg),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .ad_in(ad_in),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .a_hi(a_hi), .rd_data(rd_data), .rd_valid(rd_valid),
    .cyc_end(cyc_end)
  );

  // bench model state: 0 idle, 1 fetch, 2 read, 3 write
  int          bphase = 0, bkind = 0, cyc_idx = 0;
  logic [15:0] baddr = 0;
  logic        bwide = 0, bquiet = 0, bvalid = 0;
  logic [7:0]  bwdata = 0, brd = 0;

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h (cycle %0d phase %0d)",
               tag, what, got, exp, cyc_idx, bphase);
    end
  endtask

  function automatic logic exp_ale(int ph, int k, logic q);
    int hp = ph % 6;
    if (k < 2 && q) return 1'b1;
    if (k >= 2) return ph < 2;
    return hp < 2;
  endfunction

  function automatic logic [15:0] exp_addr_now(int ph, int k, logic [15:0] a);
    return (k == 1 && ph >= 6) ? a + 16'd1 : a;
  endfunction

  task automatic check_all();
    logic [15:0] ca;
    logic        e_oe, adrv, wdrv;
    logic [7:0]  e_out, e_hi;
    string       atag, btag;
    ca   = exp_addr_now(bphase, bkind, baddr);
    adrv = (bkind == 1) ? ((bphase % 6) < 2) : (bkind >= 2 && bphase < 2);
    wdrv = (bkind == 3) && (bphase >= 4);
    e_oe = adrv || wdrv;
    e_out = adrv ? ca[7:0] : (wdrv ? bwdata : 8'h00);
    if (bkind == 1) e_hi = ca[15:8];
    else if (bkind >= 2 && bwide) e_hi = baddr[15:8];
    else e_hi = p2_reg;
    if (bkind >= 2) atag = "R4";
    else if (cyc_idx >= 8 && cyc_idx <= 12) atag = "R10";
    else if (bquiet) atag = "R9";
    else atag = "R2";
    case (bkind)
      1: btag = "R3";
      2: btag = "R5";
      3: btag = "R6";
      default: btag = "R2";
    endcase
    chk(atag, "ale", ale, exp_ale(bphase, bkind, bquiet));
    chk("R3", "psen_n", psen_n, !(bkind == 1 && (bphase % 6) >= 3));
    chk("R5", "rd_n", rd_n, !(bkind == 2 && bphase >= 5 && bphase <= 10));
    chk("R6", "wr_n", wr_n, !(bkind == 3 && bphase >= 5 && bphase <= 10));
    chk(btag, "ad_oe", ad_oe, e_oe);
    chk(btag, "ad_out", ad_out, e_out);
    chk("R7", "a_hi", a_hi, e_hi);
    chk("R8", "cyc_end", cyc_end, bphase == 11);
    chk("R5", "rd_valid", rd_valid, bvalid);
    if (bvalid) chk("R5", "rd_data", rd_data, brd);
  endtask

  // choose the request for the next cycle; directed opening then random
  task automatic drive_request();
    int r;
    case (cyc_idx)
      0: r = 1;
      1: r = 5;
      2: r = 6;
      3: r = 7;
      4: r = 1;
      5: r = 5;
      6: r = 0;
      7: r = 1;
      8: r = 1;
      9: r = 0;
      default: r = int'($urandom % 8);
    endcase
    fetch_req  = (r >= 1 && r <= 4) || r == 7;
    data_req   = (r >= 5);
    data_we    = (r == 6);
    data_wide  = (cyc_idx == 1) ? 1'b1 : (cyc_idx == 2) ? 1'b0 : 1'($urandom);
    fetch_addr = (cyc_idx == 0) ? 16'h12FF : 16'($urandom);
    data_addr  = 16'($urandom);
    data_wdata = 8'($urandom);
  endtask

  task automatic drive_sfr();
    sfr_we = 0;
    if (cyc_idx == 3 && bphase == 4) begin
      sfr_we = 1; sfr_addr = 8'h8E; sfr_wdata = 8'h01;
    end else if (cyc_idx == 7 && bphase == 2) begin
      sfr_we = 1; sfr_addr = 8'h8F; sfr_wdata = 8'h00; // R9 ignored address
    end else if (cyc_idx == 8 && bphase == 3) begin
      sfr_we = 1; sfr_addr = 8'h8E; sfr_wdata = 8'hFE; // R10 clear
    end else if (cyc_idx > 12 && ($urandom % 40) == 0) begin
      sfr_we = 1;
      sfr_addr = (($urandom % 3) == 0) ? 8'h8D : 8'h8E;
      sfr_wdata = 8'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd2468));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "psen_n", psen_n, 1);
    chk("R1", "rd_n", rd_n, 1);
    chk("R1", "wr_n", wr_n, 1);
    chk("R1", "ad_oe", ad_oe, 0);
    chk("R1", "cyc_end", cyc_end, 0);
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "ale", ale, 1);
    rst_n = 1'b1;
    while (cyc_idx < NCYC) begin
      check_all();
      p2_reg = 8'($urandom);
      ad_in  = 8'($urandom);
      drive_sfr();
      if (bphase == 11) drive_request();
      @(negedge clk);
      // advance model by the edge just passed
      bvalid = (bkind == 2 && bphase == 10);
      if (bvalid) brd = ad_in;
      if (sfr_we && sfr_addr == 8'h8E) bquiet = sfr_wdata[0];
      if (bphase == 11) begin
        bphase = 0;
        cyc_idx++;
        if (data_req) begin
          bkind = data_we ? 3 : 2;
          baddr = data_addr;
          bwide = data_wide;
        end else begin
          bkind = fetch_req ? 1 : 0;
          baddr = fetch_addr;
          bwide = 0;
        end
        bwdata = data_wdata;
      end else begin
        bphase++;
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(NCYC * 12 * 5 + 2000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule